// File: doc/BRIEF.md
# Timer-Paced PCM Sample Buffer

This block is one streaming audio channel. A processor or a DMA engine pushes 32-bit words that each pack four signed 8-bit PCM samples. Two external timers supply one-cycle overflow pulses, and a select input picks which of them sets the sample rate. On each selected pulse the buffer releases one byte into a held sample register, starting with the least significant byte of the oldest word. The held sample goes out at full or half amplitude, and each of the left and right outputs has its own gate.

The buffer holds eight words, which is 32 samples. Its fill level is counted in bytes, so a word that has been partly played still counts for the bytes it has left. When 16 or fewer bytes remain, the block raises a refill request so that a DMA engine can push the next burst. The DMA side can acknowledge the request, which drops it for one cycle. A clear strobe empties the buffer. A master enable mutes both outputs and freezes playback.

Top module: `pcm_stream_fifo`

## Requirements
- R1: After reset both audio outputs are 0, `wr_drop` is 0 and `drq` is 1, because the buffer starts empty.
- R2: Samples leave in write order. Within a word, bits [7:0] come out first, then [15:8], [23:16] and [31:24]. Each byte is a signed two's-complement value.
- R3: Eight words are accepted from empty. A write that finds fewer than 4 free bytes is discarded, `wr_drop` is 1 in the following cycle, and the stored samples are not changed.
- R4: With `tmr_sel`=0 only `timer_tick[0]` advances playback. With `tmr_sel`=1 only `timer_tick[1]` does.
- R5: With `vol_full`=1 an enabled output carries the held sample. With `vol_full`=0 it carries the held sample shifted right arithmetically by one (-5 becomes -3, -128 becomes -64).
- R6: `en_left` and `en_right` gate `out_left` and `out_right` independently. A gated-off output is 0.
- R7: While `master_en` is 0, both outputs are 0 and timer pulses consume no samples. When `master_en` returns to 1, the same held sample appears again.
- R8: A selected timer pulse that arrives while the buffer is empty leaves the held sample unchanged.
- R9: `fifo_clear` empties the buffer in the cycle it is high. A write or a timer pulse in that same cycle is ignored, and the held sample is kept.
- R10: In each cycle after a clock edge, `drq` is 1 exactly when the fill level is 16 bytes or fewer and `drq_ack` was not high at that edge. Fill level counts every unplayed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Push `wr_data` this cycle |
| wr_data | input | 32 | Four packed signed samples, lowest byte played first |
| wr_drop | output | 1 | The write in the previous cycle was discarded because the buffer was full |
| timer_tick | input | 2 | Overflow pulses from timer 0 (bit 0) and timer 1 (bit 1) |
| tmr_sel | input | 1 | Selects the timer that paces playback |
| vol_full | input | 1 | 1 = full amplitude, 0 = half amplitude |
| en_left | input | 1 | Routes the channel to `out_left` |
| en_right | input | 1 | Routes the channel to `out_right` |
| master_en | input | 1 | Global sound enable |
| fifo_clear | input | 1 | Empties the buffer |
| drq_ack | input | 1 | DMA acknowledge of the refill request |
| drq | output | 1 | Refill request |
| out_left | output | 8 | Signed left sample |
| out_right | output | 8 | Signed right sample |

## Verification
A bad byte pointer or a bad word pointer shows up as a wrong or reordered sample at the outputs on the first pulse after the fault. A fill count that drifts shows up at `drq`. The error appears at the 16-byte threshold, or at the first write that is wrongly taken or wrongly dropped near full. A wrong count also shows when an empty buffer plays a new value instead of holding the old one. The tests load byte values that are all different, so the output value at each pulse identifies the byte that was read.

// File: rtl/pcm_fifo_pkg.sv
`timescale 1ns/1ps
package pcm_fifo_pkg;
  localparam int unsigned SAMPLE_W = 8;
  typedef logic signed [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/pcm_byte_fifo.sv
`timescale 1ns/1ps
// Word-written, byte-read ring buffer. The byte capacity must be a power of two.
module pcm_byte_fifo
  import pcm_fifo_pkg::*;
#(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned DEPTH_WORDS = 8,
  localparam int unsigned LANES  = WORD_W / SAMPLE_W,
  localparam int unsigned CAP    = DEPTH_WORDS * LANES,
  localparam int unsigned CNT_W  = $clog2(CAP + 1),
  localparam int unsigned WP_W   = $clog2(DEPTH_WORDS),
  localparam int unsigned LANE_W = $clog2(LANES),
  localparam int unsigned RP_W   = $clog2(CAP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  output sample_t           rd_data,
  output logic              rd_fire,
  output logic              wr_drop,
  output logic [CNT_W-1:0]  fill,
  output logic [CNT_W-1:0]  fill_nx
);
  logic [WORD_W-1:0] mem_q [DEPTH_WORDS];
  logic [WP_W-1:0]   wp_q, wp_d;
  logic [RP_W-1:0]   rp_q, rp_d;
  logic [CNT_W-1:0]  fill_q, fill_d;
  logic              drop_q, drop_d;
  logic              room, wr_ok;

  assign room    = fill_q <= CNT_W'(CAP - LANES);
  assign wr_ok   = wr_en & room & ~clr;
  assign rd_fire = rd_en & (fill_q != '0) & ~clr;
  assign rd_data = mem_q[rp_q[RP_W-1:LANE_W]][rp_q[LANE_W-1:0]*SAMPLE_W +: SAMPLE_W];

  always_comb begin
    wp_d   = wp_q;
    rp_d   = rp_q;
    fill_d = fill_q;
    drop_d = wr_en & ~room & ~clr;
    if (wr_ok) begin
      wp_d   = wp_q + 1'b1;
      fill_d = fill_d + CNT_W'(LANES);
    end
    if (rd_fire) begin
      rp_d   = rp_q + 1'b1;
      fill_d = fill_d - 1'b1;
    end
    if (clr) begin
      wp_d   = '0;
      rp_d   = '0;
      fill_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
      drop_q <= 1'b0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      fill_q <= fill_d;
      drop_q <= drop_d;
    end
  end

  // Storage without reset; the clock enable is the accepted write.
  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wp_q] <= wr_data;
  end

  assign wr_drop = drop_q;
  assign fill    = fill_q;
  assign fill_nx = fill_d;
endmodule

// File: rtl/pcm_refill_req.sv
`timescale 1ns/1ps
module pcm_refill_req #(
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned LOW_BYTES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fill_nx,
  input  logic             ack,
  output logic             drq
);
  logic req_q, req_d;

  assign req_d = (fill_nx <= CNT_W'(LOW_BYTES)) & ~ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b1;
    else        req_q <= req_d;
  end

  assign drq = req_q;
endmodule

// File: rtl/pcm_out_stage.sv
`timescale 1ns/1ps
module pcm_out_stage
  import pcm_fifo_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  sample_t din,
  input  logic    vol_full,
  input  logic    en_l,
  input  logic    en_r,
  input  logic    master,
  output sample_t out_l,
  output sample_t out_r
);
  sample_t held_q, held_d, scaled;

  assign held_d = load ? din : held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  assign scaled = vol_full ? held_q : (held_q >>> 1);
  assign out_l  = (master & en_l) ? scaled : '0;
  assign out_r  = (master & en_r) ? scaled : '0;
endmodule

// File: rtl/pcm_stream_fifo.sv
`timescale 1ns/1ps
module pcm_stream_fifo
  import pcm_fifo_pkg::*;
#(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned DEPTH_WORDS = 8,
  parameter int unsigned LOW_WORDS   = 4,
  localparam int unsigned LANES = WORD_W / SAMPLE_W,
  localparam int unsigned CAP   = DEPTH_WORDS * LANES,
  localparam int unsigned CNT_W = $clog2(CAP + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  input  logic [WORD_W-1:0]   wr_data,
  output logic                wr_drop,
  input  logic [1:0]          timer_tick,
  input  logic                tmr_sel,
  input  logic                vol_full,
  input  logic                en_left,
  input  logic                en_right,
  input  logic                master_en,
  input  logic                fifo_clear,
  input  logic                drq_ack,
  output logic                drq,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right
);
  logic             tick_sel, pop_req, pop_fire;
  sample_t          head, o_l, o_r;
  logic [CNT_W-1:0] fill_cnt, fill_nx;

  assign tick_sel = tmr_sel ? timer_tick[1] : timer_tick[0];
  assign pop_req  = tick_sel & master_en;

  pcm_byte_fifo #(.WORD_W(WORD_W), .DEPTH_WORDS(DEPTH_WORDS)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clear), .wr_en(wr_valid),
    .wr_data(wr_data), .rd_en(pop_req), .rd_data(head), .rd_fire(pop_fire),
    .wr_drop(wr_drop), .fill(fill_cnt), .fill_nx(fill_nx)
  );

  pcm_refill_req #(.CNT_W(CNT_W), .LOW_BYTES(LOW_WORDS * LANES)) u_req (
    .clk(clk), .rst_n(rst_n), .fill_nx(fill_nx), .ack(drq_ack), .drq(drq)
  );

  pcm_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .load(pop_fire), .din(head),
    .vol_full(vol_full), .en_l(en_left), .en_r(en_right), .master(master_en),
    .out_l(o_l), .out_r(o_r)
  );

  assign out_left  = o_l;
  assign out_right = o_r;
endmodule

// File: rtl/pcm_stream_fifo_chk.sv
`timescale 1ns/1ps
module pcm_stream_fifo_chk #(
  parameter int unsigned CAP   = 32,
  parameter int unsigned CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_drop,
  input logic             en_left,
  input logic             master_en,
  input logic             fifo_clear,
  input logic             drq_ack,
  input logic             drq,
  input logic [7:0]       out_left,
  input logic [7:0]       out_right,
  input logic [CNT_W-1:0] fill
);
  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(CAP));
  p_drop_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |-> $past(wr_valid));
  p_gate_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_left |-> out_left == '0);
  p_master_mute_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> (out_left == '0 && out_right == '0));
  p_empty_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0 && !wr_valid) |=> fill == '0);
  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clear |=> fill == '0);
  p_ack_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drq_ack |=> !drq);
endmodule

bind pcm_stream_fifo pcm_stream_fifo_chk #(.CAP(CAP), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_drop(wr_drop),
  .en_left(en_left), .master_en(master_en), .fifo_clear(fifo_clear),
  .drq_ack(drq_ack), .drq(drq), .out_left(out_left), .out_right(out_right),
  .fill(fill_cnt)
);

// File: tb/tb_pcm_stream_fifo.sv
`timescale 1ns/1ps
module tb_pcm_stream_fifo;
  logic        clk, rst_n;
  logic        wr_valid, wr_drop, tmr_sel, vol_full, en_left, en_right;
  logic        master_en, fifo_clear, drq_ack, drq;
  logic [31:0] wr_data;
  logic [1:0]  timer_tick;
  logic [7:0]  out_left, out_right;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  pcm_stream_fifo dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_drop(wr_drop), .timer_tick(timer_tick), .tmr_sel(tmr_sel),
    .vol_full(vol_full), .en_left(en_left), .en_right(en_right),
    .master_en(master_en), .fifo_clear(fifo_clear), .drq_ack(drq_ack),
    .drq(drq), .out_left(out_left), .out_right(out_right)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // word, vol_full, en_left, en_right, tmr_sel, expected left, expected right
  typedef struct packed {
    logic [31:0] word;
    logic vol, l, r, sel;
    logic [31:0] exp_l, exp_r;
  } vec_t;
  localparam vec_t VECS [4] = '{
    '{32'h807F01FE, 1'b1, 1'b1, 1'b1, 1'b0, 32'h807F01FE, 32'h807F01FE},
    '{32'h807F01FE, 1'b0, 1'b1, 1'b0, 1'b1, 32'hC03F00FF, 32'h00000000},
    '{32'h03FB10F0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h00000000, 32'h01FD08F8},
    '{32'hC83700FF, 1'b1, 1'b1, 1'b1, 1'b1, 32'hC83700FF, 32'hC83700FF}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push(input logic [31:0] w);
    wr_valid = 1; wr_data = w; step(); wr_valid = 0;
  endtask

  task automatic tick(input int t);
    timer_tick[t] = 1'b1; step(); timer_tick = '0;
  endtask

  task automatic clear();
    fifo_clear = 1; step(); fifo_clear = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; wr_valid = 0; wr_data = '0; timer_tick = '0; tmr_sel = 0;
    vol_full = 1; en_left = 1; en_right = 1; master_en = 1;
    fifo_clear = 0; drq_ack = 0;
    repeat (3) step();
    rst_n = 1; step();
    // R1 reset state
    check(out_left == 0 && out_right == 0, "R1 outputs", {out_left, out_right}, 0);
    check(drq == 1, "R1 drq", drq, 1);
    check(wr_drop == 0, "R1 wr_drop", wr_drop, 0);

    // Vector table: R2, R4, R5, R6
    for (int v = 0; v < 4; v++) begin
      clear();
      vol_full = VECS[v].vol; en_left = VECS[v].l; en_right = VECS[v].r;
      tmr_sel = VECS[v].sel;
      push(VECS[v].word);
      tick(VECS[v].sel ? 0 : 1);   // R4: unselected timer must not pop
      for (int k = 0; k < 4; k++) begin
        tick(VECS[v].sel ? 1 : 0);
        check(out_left == VECS[v].exp_l[k*8 +: 8], "R2/R4/R5/R6 left",
              out_left, VECS[v].exp_l[k*8 +: 8]);
        check(out_right == VECS[v].exp_r[k*8 +: 8], "R2/R4/R5/R6 right",
              out_right, VECS[v].exp_r[k*8 +: 8]);
      end
    end

    // R3 capacity, R10 threshold, R8 empty hold
    vol_full = 1; en_left = 1; en_right = 1; tmr_sel = 0;
    clear();
    for (int i = 0; i < 8; i++) begin
      push({8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
      check(wr_drop == 0, "R3 accept", wr_drop, 0);
      if (i == 3) check(drq == 1, "R10 at 16 bytes", drq, 1);
      if (i == 4) check(drq == 0, "R10 at 20 bytes", drq, 0);
    end
    push(32'hAAAAAAAA);
    check(wr_drop == 1, "R3 drop when full", wr_drop, 1);
    step();
    check(wr_drop == 0, "R3 drop pulse ends", wr_drop, 0);
    for (int p = 1; p <= 32; p++) begin
      tick(0);
      check(out_left == 8'(p-1), "R3 stored order", out_left, p-1);
      if (p == 15) check(drq == 0, "R10 17 bytes left", drq, 0);
      if (p == 16) check(drq == 1, "R10 16 bytes left", drq, 1);
    end
    tick(0);
    check(out_left == 8'd31, "R8 empty tick holds", out_left, 31);

    // R10 acknowledge
    drq_ack = 1; step(); drq_ack = 0;
    check(drq == 0, "R10 ack drops", drq, 0);
    step();
    check(drq == 1, "R10 request returns", drq, 1);

    // R7 master enable
    push(32'h44332211);
    tick(0);
    check(out_left == 8'h11, "R7 first sample", out_left, 8'h11);
    master_en = 0; step();
    check(out_left == 0 && out_right == 0, "R7 muted", {out_left, out_right}, 0);
    tick(0);
    master_en = 1; step();
    check(out_left == 8'h11, "R7 held after mute", out_left, 8'h11);
    tick(0);
    check(out_left == 8'h22, "R7 no consume while muted", out_left, 8'h22);

    // R9 clear beats write and tick
    wr_valid = 1; wr_data = 32'h77665555; timer_tick = 2'b01; fifo_clear = 1;
    step();
    wr_valid = 0; timer_tick = '0; fifo_clear = 0;
    check(out_left == 8'h22, "R9 tick ignored on clear", out_left, 8'h22);
    check(drq == 1, "R9 empty after clear", drq, 1);
    tick(0);
    check(out_left == 8'h22, "R9 write ignored on clear", out_left, 8'h22);

    finish_run();
  end
endmodule